// File: doc/BRIEF.md
# Vector Byte Table Lookup Unit

This unit executes a byte-wise table lookup on 128-bit vector registers. A decoded 32-bit instruction word names an index register, a destination register and a run of one to four consecutive table registers. Every byte of the index register picks one byte out of the concatenated tables. An index past the end of the tables gives either zero (plain form) or the byte the destination already holds (extend form). A narrow mode keeps only the low 64 bits of the result and clears the rest.

The unit shares one read port of a 32-entry register file. Reads have a one-cycle latency. It fetches the index register first, then the old destination (extend form only), then the table registers in ascending order, one per cycle. As each table arrives it folds that table's matches into an accumulator, so no table is stored. One cycle after the last read returns, it writes the result through a single write port. It pulses done in that same cycle. A word that does not match the encoding is flagged and dropped.

Top module: `vtbl_unit`

## Requirements
- R1: A word is accepted only when bit 31 = 0, bits 29:21 = 001110000, bit 15 = 0 and bits 11:10 = 00. When `start` brings any other word in the idle state, `illegal` is high for exactly the next cycle. No register is read or written, and the unit stays idle.
- R2: Register fields are index m = bits 20:16, first table n = bits 9:5, destination d = bits 4:0, and length code len = bits 14:13. Reads are issued one per cycle in this order: m, then d if bit 12 = 1, then the table registers.
- R3: The table is the len+1 registers n+0 … n+len, each taken modulo 32, so numbering wraps from 31 to 0.
- R4: Byte i of a register is bits 8i+7:8i. Suppose index byte i holds value v and v < 16·(len+1). Then result byte i is byte (v mod 16) of table register number floor(v/16).
- R5: When bit 12 = 0, each result byte whose index is 16·(len+1) or more is 0x00. This includes index 255.
- R6: When bit 12 = 1, each such out-of-range result byte equals the same byte of the destination register as read before the operation.
- R7: When bit 30 = 0, bits 127:64 of the written value are zero. Bits 63:0 follow R4 to R6. When bit 30 = 1, all 128 bits follow R4 to R6.
- R8: `busy` rises in the cycle after an accepted `start` and stays high until the write cycle. In that cycle `rf_wr_en` and `done` are high together for one cycle, with `rf_wr_addr` = d. `busy` is low in the following cycle.
- R9: A `start` while `busy` is ignored. The running operation completes unchanged, and there is no second write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation with `instr` |
| instr | input | 32 | Instruction word |
| busy | output | 1 | Operation in progress |
| illegal | output | 1 | One-cycle flag for a non-matching word |
| done | output | 1 | One-cycle completion pulse |
| rf_rd_en | output | 1 | Register file read request |
| rf_rd_addr | output | 5 | Register number to read |
| rf_rd_data | input | 128 | Read data, valid the cycle after the request |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_addr | output | 5 | Register number to write |
| rf_wr_data | output | 128 | Result to write |

## Verification
The assertions assume that `start` is a single-cycle pulse. They also assume the register file returns the data one cycle after each read request. The bench keeps to both: it raises `start` for exactly one cycle, and its register model registers the read data on the clock edge after the request. The single-pulse illegal check in particular relies on `start` not being held across two cycles with a bad word. The stimulus never does that.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
  localparam int VREG_W  = 128;
  localparam int LANES   = VREG_W / 8;
  localparam int RADDR_W = 5;
  localparam int STEP_W  = 3;

  typedef struct packed {
    logic               legal;
    logic               wide;
    logic               extend;
    logic [1:0]         len;
    logic [RADDR_W-1:0] m;
    logic [RADDR_W-1:0] n;
    logic [RADDR_W-1:0] d;
  } vtbl_op_t;

  function automatic vtbl_op_t decode_word(input logic [31:0] w);
    vtbl_op_t o;
    o.legal  = !w[31] && (w[29:21] == 9'b001110000) && !w[15] && (w[11:10] == 2'b00);
    o.wide   = w[30];
    o.extend = w[12];
    o.len    = w[14:13];
    o.m      = w[20:16];
    o.n      = w[9:5];
    o.d      = w[4:0];
    return o;
  endfunction

  // {hit, byte}: index ix looked up in table number k
  function automatic logic [8:0] pick_byte(input logic [VREG_W-1:0] tab,
                                           input logic [7:0] ix,
                                           input logic [1:0] k);
    logic [7:0] rel;
    rel = ix - {2'b00, k, 4'b0000};
    return {(rel < 8'd16), tab[{rel[3:0], 3'b000} +: 8]};
  endfunction

  function automatic logic in_table(input logic [7:0] ix, input logic [1:0] len);
    logic [8:0] limit;
    limit = ({7'd0, len} + 9'd1) << 4;
    return {1'b0, ix} < limit;
  endfunction
endpackage

// File: rtl/vtbl_decode.sv
module vtbl_decode
  import vtbl_pkg::*;
(
  input  logic [31:0] word,
  output vtbl_op_t    op
);
  always_comb op = decode_word(word);
endmodule

// File: rtl/vtbl_seq.sv
module vtbl_seq
  import vtbl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  vtbl_op_t           op_in,
  output vtbl_op_t           op_q,
  output logic               busy,
  output logic               illegal,
  output logic               wr_phase,
  output logic               rd_en,
  output logic [RADDR_W-1:0] rd_addr,
  output logic               cap_idx,
  output logic               cap_old,
  output logic               cap_tab,
  output logic [1:0]         cap_k
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_DRAIN, S_WRITE} state_t;
  state_t            state;
  logic [STEP_W-1:0] iss, rcv_step, last_step, tab_step, rcv_tab;
  logic              rcv_v;

  assign last_step = {{(STEP_W-1){1'b0}}, op_q.extend} + {1'b0, op_q.len} + STEP_W'(1);
  assign tab_step  = iss - STEP_W'(1) - {{(STEP_W-1){1'b0}}, op_q.extend};
  assign rcv_tab   = rcv_step - STEP_W'(1) - {{(STEP_W-1){1'b0}}, op_q.extend};

  assign busy     = (state != S_IDLE);
  assign wr_phase = (state == S_WRITE);
  assign rd_en    = (state == S_READ);

  always_comb begin
    if (iss == '0)                   rd_addr = op_q.m;
    else if (op_q.extend && iss == 1) rd_addr = op_q.d;
    else                             rd_addr = op_q.n + RADDR_W'(tab_step[1:0]);
  end

  assign cap_idx = rcv_v && (rcv_step == '0);
  assign cap_old = rcv_v && op_q.extend && (rcv_step == STEP_W'(1));
  assign cap_tab = rcv_v && !cap_idx && !cap_old;
  assign cap_k   = rcv_tab[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= '0;
      iss      <= '0;
      rcv_v    <= 1'b0;
      rcv_step <= '0;
      illegal  <= 1'b0;
    end else begin
      rcv_v    <= rd_en;
      rcv_step <= iss;
      illegal  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (op_in.legal) begin
            op_q  <= op_in;
            iss   <= '0;
            state <= S_READ;
          end else begin
            illegal <= 1'b1;
          end
        end
        S_READ: begin
          iss <= iss + STEP_W'(1);
          if (iss == last_step) state <= S_DRAIN;
        end
        S_DRAIN: state <= S_WRITE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vtbl_lanes.sv
module vtbl_lanes
  import vtbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VREG_W-1:0] rd_data,
  input  logic              cap_idx,
  input  logic              cap_old,
  input  logic              cap_tab,
  input  logic [1:0]        cap_k,
  input  logic [1:0]        len,
  input  logic              extend,
  input  logic              wide,
  output logic [VREG_W-1:0] result
);
  logic [VREG_W-1:0] idx_q, old_q, acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      old_q <= '0;
    end else begin
      if (cap_idx) idx_q <= rd_data;
      if (cap_old) old_q <= rd_data;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [8:0] hit_byte;
    logic [7:0] merged;
    assign hit_byte = pick_byte(rd_data, idx_q[8*i +: 8], cap_k);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      acc_q[8*i +: 8] <= '0;
      else if (cap_idx)                acc_q[8*i +: 8] <= '0;
      else if (cap_tab && hit_byte[8]) acc_q[8*i +: 8] <= acc_q[8*i +: 8] | hit_byte[7:0];
    end

    assign merged = in_table(idx_q[8*i +: 8], len) ? acc_q[8*i +: 8]
                  : (extend ? old_q[8*i +: 8] : 8'h00);

    if (i >= LANES/2) begin : g_hi
      assign result[8*i +: 8] = wide ? merged : 8'h00;
    end else begin : g_lo
      assign result[8*i +: 8] = merged;
    end
  end
endmodule

// File: rtl/vtbl_unit.sv
module vtbl_unit
  import vtbl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [31:0]        instr,
  output logic               busy,
  output logic               illegal,
  output logic               done,
  output logic               rf_rd_en,
  output logic [RADDR_W-1:0] rf_rd_addr,
  input  logic [VREG_W-1:0]  rf_rd_data,
  output logic               rf_wr_en,
  output logic [RADDR_W-1:0] rf_wr_addr,
  output logic [VREG_W-1:0]  rf_wr_data
);
  vtbl_op_t   op_dec, op_q;
  logic       wr_phase, cap_idx, cap_old, cap_tab;
  logic [1:0] cap_k;
  logic       cur_wide;

  assign cur_wide = op_q.wide;

  vtbl_decode u_dec (.word(instr), .op(op_dec));

  vtbl_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_dec), .op_q(op_q),
    .busy(busy), .illegal(illegal), .wr_phase(wr_phase),
    .rd_en(rf_rd_en), .rd_addr(rf_rd_addr),
    .cap_idx(cap_idx), .cap_old(cap_old), .cap_tab(cap_tab), .cap_k(cap_k)
  );

  vtbl_lanes u_lanes (
    .clk(clk), .rst_n(rst_n), .rd_data(rf_rd_data),
    .cap_idx(cap_idx), .cap_old(cap_old), .cap_tab(cap_tab), .cap_k(cap_k),
    .len(op_q.len), .extend(op_q.extend), .wide(op_q.wide), .result(rf_wr_data)
  );

  assign rf_wr_en   = wr_phase;
  assign done       = wr_phase;
  assign rf_wr_addr = op_q.d;
endmodule

// File: rtl/vtbl_unit_chk.sv
module vtbl_unit_chk #(parameter int DW = 128) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          illegal,
  input logic          done,
  input logic          rf_rd_en,
  input logic          rf_wr_en,
  input logic [DW-1:0] rf_wr_data,
  input logic          cur_wide
);
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!rf_rd_en && !rf_wr_en && !busy)); // R1
  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal); // R1
  AST_READ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |-> busy); // R2
  AST_NO_READ_AT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> !rf_rd_en); // R2
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en && !cur_wide) |-> (rf_wr_data[DW-1:DW/2] == '0)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R9
endmodule

bind vtbl_unit vtbl_unit_chk #(.DW(vtbl_pkg::VREG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .illegal(illegal), .done(done),
  .rf_rd_en(rf_rd_en), .rf_wr_en(rf_wr_en), .rf_wr_data(rf_wr_data),
  .cur_wide(cur_wide)
);

// File: tb/vtbl_unit_tb.sv
module vtbl_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  instr = '0;
  logic         busy, illegal, done, rf_rd_en, rf_wr_en;
  logic [4:0]   rf_rd_addr, rf_wr_addr;
  logic [127:0] rf_rd_data, rf_wr_data;

  logic [127:0] rf [32];
  int total = 0, bad = 0, cycles = 0;
  logic [4:0] rlog [16];
  int nlog = 0;

  always #5 clk = ~clk;

  vtbl_unit u_dut (.*);

  always @(posedge clk) begin
    if (rf_rd_en) rf_rd_data <= rf[rf_rd_addr];
    if (rf_wr_en) rf[rf_wr_addr] <= rf_wr_data;
  end

  always @(negedge clk) begin
    cycles++;
    if (rf_rd_en && nlog < 16) begin rlog[nlog] = rf_rd_addr; nlog++; end
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(bit q, bit x, logic [1:0] len, logic [4:0] n, logic [4:0] m, logic [4:0] d);
    return {1'b0, q, 9'b001110000, m, 1'b0, len, x, 2'b00, n, d};
  endfunction

  // independent byte-level model of the requirements
  function automatic logic [127:0] model(bit q, bit x, logic [1:0] len, logic [4:0] n, logic [4:0] m, logic [4:0] d);
    logic [127:0] r;
    int v, reg_no, lanes;
    r = '0;
    lanes = q ? 16 : 8;
    for (int i = 0; i < lanes; i++) begin
      v = int'(rf[m][8*i +: 8]);
      if (v < 16 * (int'(len) + 1)) begin
        reg_no = (int'(n) + v / 16) % 32;
        r[8*i +: 8] = rf[reg_no][8*(v % 16) +: 8];
      end else if (x) r[8*i +: 8] = rf[d][8*i +: 8];
    end
    return r;
  endfunction

  task automatic fill_regs();
    for (int r = 0; r < 32; r++)
      for (int j = 0; j < 16; j++)
        rf[r][8*j +: 8] = 8'(r * 37 + j * 11 + 1);
  endtask

  function automatic logic [127:0] idx_pattern(int salt);
    logic [127:0] p;
    byte unsigned vals [16] = '{0, 15, 16, 63, 64, 255, 1, 31, 32, 47, 48, 17, 200, 14, 65, 33};
    for (int i = 0; i < 16; i++) p[8*i +: 8] = vals[(i + salt) % 16];
    return p;
  endfunction

  task automatic pulse(input logic [31:0] w);
    @(negedge clk); instr = w; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_op(input string req, input bit q, input bit x, input logic [1:0] len,
                        input logic [4:0] n, input logic [4:0] m, input logic [4:0] d, input int salt);
    logic [127:0] exp, act;
    logic [4:0] exp_seq [6];
    int nexp, k;
    bit seen, order_ok;
    rf[m] = idx_pattern(salt);
    exp = model(q, x, len, n, m, d);
    nexp = 0;
    exp_seq[nexp] = m; nexp++;
    if (x) begin exp_seq[nexp] = d; nexp++; end
    for (int t = 0; t <= int'(len); t++) begin exp_seq[nexp] = 5'((int'(n) + t) % 32); nexp++; end
    nlog = 0;
    seen = 0;
    act = '0;
    pulse(enc(q, x, len, n, m, d));
    chk(busy == 1'b1, "R8 busy after start", 128'(busy), 128'd1);
    k = 0;
    while (!seen && k < 40) begin
      if (done) begin
        seen = 1;
        act = rf_wr_data;
        chk(rf_wr_en == 1'b1, "R8 write with done", 128'(rf_wr_en), 128'd1);
        chk(rf_wr_addr == d, "R8 write address", 128'(rf_wr_addr), 128'(d));
      end else begin
        @(negedge clk); k++;
      end
    end
    chk(seen, "R8 done seen", 128'(seen), 128'd1);
    chk(act == exp, req, act, exp);
    order_ok = (nlog == nexp);
    for (int t = 0; t < nexp && t < nlog; t++) if (rlog[t] != exp_seq[t]) order_ok = 0;
    chk(order_ok, "R2 R3 read order", 128'(nlog), 128'(nexp));
    @(negedge clk);
    chk(!busy && !done, "R8 idle after done", {126'd0, busy, done}, 128'd0);
  endtask

  task automatic t_reset();
    chk({busy, illegal, done, rf_rd_en, rf_wr_en} == 5'b0, "R8 reset outputs",
        128'({busy, illegal, done, rf_rd_en, rf_wr_en}), 128'd0);
  endtask

  task automatic t_illegal();
    logic [31:0] good, words [3];
    bit any_io;
    good = enc(1, 0, 2'd1, 5'd4, 5'd2, 5'd9);
    words[0] = good | 32'h8000_0000;
    words[1] = good | 32'h0000_8000;
    words[2] = good | 32'h0000_0400;
    for (int w = 0; w < 3; w++) begin
      nlog = 0;
      pulse(words[w]);
      chk(illegal == 1'b1, "R1 illegal flagged", 128'(illegal), 128'd1);
      any_io = 0;
      @(negedge clk);
      chk(illegal == 1'b0, "R1 illegal one cycle", 128'(illegal), 128'd0);
      for (int c = 0; c < 8; c++) begin
        if (busy || done || rf_wr_en) any_io = 1;
        @(negedge clk);
      end
      chk(!any_io && nlog == 0, "R1 no access", 128'(nlog), 128'd0);
    end
  endtask

  task automatic t_plain_lengths();
    for (int l = 0; l < 4; l++) run_op("R4 R5 plain lookup", 1, 0, 2'(l), 5'd4, 5'd1, 5'd20, l);
  endtask

  task automatic t_extend();
    run_op("R6 extend len0", 1, 1, 2'd0, 5'd8, 5'd2, 5'd21, 3);
    run_op("R6 extend len3", 1, 1, 2'd3, 5'd8, 5'd2, 5'd22, 5);
  endtask

  task automatic t_narrow();
    run_op("R7 narrow plain", 0, 0, 2'd2, 5'd12, 5'd3, 5'd23, 0);
    run_op("R7 narrow extend", 0, 1, 2'd1, 5'd12, 5'd3, 5'd24, 7);
  endtask

  task automatic t_wrap();
    run_op("R3 wrap from 30", 1, 0, 2'd3, 5'd30, 5'd5, 5'd25, 2);
    run_op("R3 wrap from 31", 1, 1, 2'd1, 5'd31, 5'd6, 5'd26, 4);
  endtask

  task automatic t_start_busy();
    logic [127:0] exp;
    int ndone;
    logic [4:0] addr_seen;
    logic [127:0] act;
    rf[7] = idx_pattern(9);
    exp = model(1, 0, 2'd3, 5'd16, 5'd7, 5'd27);
    ndone = 0; act = '0; addr_seen = '0;
    pulse(enc(1, 0, 2'd3, 5'd16, 5'd7, 5'd27));
    @(negedge clk);
    pulse(enc(1, 1, 2'd0, 5'd2, 5'd7, 5'd28));
    for (int c = 0; c < 30; c++) begin
      if (done) begin ndone++; act = rf_wr_data; addr_seen = rf_wr_addr; end
      @(negedge clk);
    end
    chk(ndone == 1, "R9 single write", 128'(ndone), 128'd1);
    chk(addr_seen == 5'd27 && act == exp, "R9 first op kept", act, exp);
  endtask

  initial begin
    fill_regs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_illegal();
    t_plain_lengths();
    t_extend();
    t_narrow();
    t_wrap();
    t_start_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule